// File: doc/BRIEF.md
# Parallel EEPROM Page Write Controller

This controller sits on the host side of an asynchronous parallel EEPROM and turns a simple request into the strobe sequence the memory needs to load and commit a page. The host pulses `start` with a byte count and then offers address/data pairs through a valid/ready handshake. The controller drives the memory's address and data buses and its active-low chip-enable, output-enable and write-enable lines. Each write pulse is stretched so that the data setup, address hold and write-pulse minimums are all met. Chip-enable stays low across the whole page load, and output-enable never leaves its inactive level.

The memory starts its internal programming cycle on its own if the next write pulse does not fall within a bounded window after the previous rising edge. The controller therefore withdraws `in_ready` once that window is about to close. If the host stalls past it, the controller ends the page there. A pair whose address lies in a different page is also held back, and the page ends. In both cases the controller waits out the full programming time and then carries on with the bytes still owed in a new page. `done` pulses once every requested byte has been loaded and the last programming wait has elapsed.

All timing figures are given in nanoseconds and converted to clock cycles from the clock-period parameter. Each conversion rounds up and never gives less than one cycle. After reset, the controller stays quiet for the power-up inhibit time before it accepts a request.

Top module: `eeprom_page_writer`

## Requirements
- R1: For INIT_CYC cycles after reset release, `busy` is high, `in_ready` is low, and chip-enable and write-enable stay high. INIT_CYC is the power-up inhibit time in cycles.
- R2: `ee_oe_n` is 1 at all times.
- R3: Each write-enable low pulse lasts exactly LOW_CYC cycles. LOW_CYC is the largest of the write-pulse, data-setup and address-hold minimums in cycles. `ee_addr` and `ee_data` stay unchanged while write-enable is low and in the cycle in which it returns high.
- R4: Chip-enable is low from the first cycle of a page load through the high cycle after the last pulse of that page. It is high while idle, during the inhibit time and during programming waits. Write-enable is never low while chip-enable is high.
- R5: `in_ready` is high only while a page load is waiting for a byte. After the first byte of a page, it is high only while the gap counter is below GAP_MAX. The gap counter counts waiting cycles since the last write-enable rising edge, and GAP_MAX is the byte-load window in cycles minus 2, with a floor of 1.
- R6: When the gap counter reaches GAP_MAX without a transfer, the page ends and a programming wait begins. The bytes still owed are then loaded in a new page.
- R7: After the first byte of a page, a pair whose address bits above log2(PAGE_BYTES) differ from that page is not accepted. The page ends, and that pair opens the next page after the programming wait.
- R8: A programming wait lasts WC_CYC cycles. During it, `in_ready` is low and chip-enable and write-enable are high.
- R9: `done` is a one-cycle pulse in the first idle cycle after the programming wait that follows the last requested byte. `busy` is low whenever the controller is idle.
- R10: `start` is ignored while `busy` is high, and a `start` with `count` equal to 0 is ignored.
- R11: The bytes written to the memory, sampled at write-enable rising edges, are exactly the accepted pairs, in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| count | input | CNT_W | Number of bytes in the request |
| in_valid | input | 1 | Address/data pair offered |
| in_addr | input | ADDR_W | Byte address of the offered pair |
| in_data | input | DATA_W | Byte value of the offered pair |
| in_ready | output | 1 | Pair accepted when high together with in_valid |
| ee_addr | output | ADDR_W | Memory address bus |
| ee_data | output | DATA_W | Memory data bus |
| ee_ce_n | output | 1 | Memory chip-enable, active low |
| ee_oe_n | output | 1 | Memory output-enable, held inactive |
| ee_we_n | output | 1 | Memory write-enable, active low |
| busy | output | 1 | High outside the idle state |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the two early page endings. Each one happens only when the host's timing or addressing lines up exactly with the controller's internal window. The stimulus uses a short byte-load window and an 8-byte page. It starts one burst two bytes below a page boundary, so the split happens on the third pair. It stalls a second burst well past the window, and it pauses a third burst for a gap still inside the window. A start pulse issued during a programming wait, and a zero-length start, show that both are dropped.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 8,
  parameter int PAGE_BYTES    = 64,
  parameter int T_WP_NS       = 100,
  parameter int T_DS_NS       = 50,
  parameter int T_AH_NS       = 50,
  parameter int T_BLC_NS      = 100000,
  parameter int T_WC_NS       = 5000000,
  parameter int T_INIT_NS     = 10000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [ADDR_W-1:0] ee_addr,
  output logic [DATA_W-1:0] ee_data,
  output logic              ee_ce_n,
  output logic              ee_oe_n,
  output logic              ee_we_n,
  output logic              busy,
  output logic              done
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LOW_CYC  = max2(to_cyc(T_WP_NS), max2(to_cyc(T_DS_NS), to_cyc(T_AH_NS)));
  localparam int BLC_CYC  = to_cyc(T_BLC_NS);
  localparam int GAP_MAX  = max2(1, BLC_CYC - 2);
  localparam int WC_CYC   = to_cyc(T_WC_NS);
  localparam int INIT_CYC = to_cyc(T_INIT_NS);
  localparam int PB       = $clog2(PAGE_BYTES);
  localparam int PG_W     = ADDR_W - PB;

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_WAIT, S_LOW, S_HIGH, S_WC} st_t;

  st_t             st;
  logic [31:0]     timer;
  logic [31:0]     gap;
  logic [CNT_W-1:0] rem;
  logic            first;
  logic [PG_W-1:0] page;

  logic same_page, gap_ok, accept, close_page;

  assign same_page  = in_addr[ADDR_W-1:PB] == page;
  assign gap_ok     = gap < 32'(GAP_MAX);
  assign in_ready   = (st == S_WAIT) && (first || (gap_ok && same_page));
  assign accept     = in_valid && in_ready;
  assign close_page = (st == S_WAIT) && !first && !accept &&
                      (!gap_ok || (in_valid && !same_page));

  assign ee_we_n = (st != S_LOW);
  assign ee_ce_n = !((st == S_WAIT) || (st == S_LOW) || (st == S_HIGH));
  assign ee_oe_n = 1'b1;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_INIT;
      timer   <= 32'(INIT_CYC);
      gap     <= '0;
      rem     <= '0;
      first   <= 1'b1;
      page    <= '0;
      ee_addr <= '0;
      ee_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_INIT: begin
          if (timer <= 32'd1) st <= S_IDLE;
          else timer <= timer - 32'd1;
        end
        S_IDLE: begin
          if (start && (count != '0)) begin
            rem   <= count;
            first <= 1'b1;
            gap   <= '0;
            st    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (accept) begin
            ee_addr <= in_addr;
            ee_data <= in_data;
            page    <= in_addr[ADDR_W-1:PB];
            rem     <= rem - 1'b1;
            first   <= 1'b0;
            timer   <= 32'(LOW_CYC);
            st      <= S_LOW;
          end else if (close_page) begin
            timer <= 32'(WC_CYC);
            st    <= S_WC;
          end else if (!first) begin
            gap <= gap + 32'd1;
          end
        end
        S_LOW: begin
          if (timer <= 32'd1) st <= S_HIGH;
          else timer <= timer - 32'd1;
        end
        S_HIGH: begin
          gap <= '0;
          if (rem == '0) begin
            timer <= 32'(WC_CYC);
            st    <= S_WC;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WC: begin
          if (timer <= 32'd1) begin
            if (rem == '0) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              first <= 1'b1;
              gap   <= '0;
              st    <= S_WAIT;
            end
          end else begin
            timer <= timer - 32'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int INIT_CYC = 1,
  parameter int LOW_CYC  = 1,
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ee_we_n,
  input logic              ee_ce_n,
  input logic              ee_oe_n,
  input logic [ADDR_W-1:0] ee_addr,
  input logic [DATA_W-1:0] ee_data,
  input logic              in_ready,
  input logic              busy,
  input logic              done
);

  int since_rst;
  int low_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= 0;
      low_len   <= 0;
    end else begin
      if (since_rst < INIT_CYC + 2) since_rst <= since_rst + 1;
      low_len <= ee_we_n ? 0 : low_len + 1;
    end
  end

  a_r1_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < INIT_CYC) |-> (ee_ce_n && ee_we_n && !in_ready && busy));

  a_r2_oe_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    ee_oe_n);

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_we_n) |-> (low_len == LOW_CYC));

  a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |=> ($stable(ee_addr) && $stable(ee_data)));

  a_r4_we_within_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |-> !ee_ce_n);

  a_r5_ready_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ee_ce_n && ee_we_n));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .INIT_CYC(INIT_CYC), .LOW_CYC(LOW_CYC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_we_n(ee_we_n), .ee_ce_n(ee_ce_n),
  .ee_oe_n(ee_oe_n), .ee_addr(ee_addr), .ee_data(ee_data),
  .in_ready(in_ready), .busy(busy), .done(done)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
  localparam int AW = 15, DW = 8, CW = 8;
  localparam int PERIOD = 10;
  localparam int LOWC = 10, WCC = 200, INITC = 100, GAPM = 28, PAGEB = 8;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [CW-1:0] count = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, ee_ce_n, ee_oe_n, ee_we_n, busy, done;
  logic [AW-1:0] ee_addr;
  logic [DW-1:0] ee_data;

  eeprom_page_writer #(
    .CLK_PERIOD_NS(PERIOD), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .PAGE_BYTES(PAGEB),
    .T_WP_NS(100), .T_DS_NS(50), .T_AH_NS(45), .T_BLC_NS(300),
    .T_WC_NS(2000), .T_INIT_NS(995)
  ) u_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count), .in_valid(in_valid),
    .in_addr(in_addr), .in_data(in_data), .in_ready(in_ready), .ee_addr(ee_addr),
    .ee_data(ee_data), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
    .busy(busy), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;

  task automatic cmp(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // reference model: phases 0 inhibit,1 idle,2 waiting,3 pulse,4 release,5 programming
  int m_ph = 0, m_t = INITC, m_gap = 0, m_rem = 0, m_first = 1, m_page = 0;
  int m_addr = 0, m_data = 0, m_done = 0, m_acc = 0;

  function automatic int m_ready();
    if (m_ph != 2) return 0;
    if (m_first) return 1;
    return (m_gap < GAPM && (int'(in_addr) / PAGEB) == m_page) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    m_acc = 0;
    if (!rst_n) begin
      m_ph = 0; m_t = INITC; m_gap = 0; m_rem = 0; m_first = 1; m_done = 0;
      m_addr = 0; m_data = 0; m_page = 0;
    end else begin
      int rdy;
      rdy = m_ready();
      m_done = 0;
      case (m_ph)
        0: begin m_t--; if (m_t == 0) m_ph = 1; end
        1: if (start && count != 0) begin m_rem = count; m_first = 1; m_gap = 0; m_ph = 2; end
        2: begin
          if (in_valid && rdy) begin
            m_acc = 1; m_addr = in_addr; m_data = in_data; m_page = int'(in_addr) / PAGEB;
            m_rem--; m_first = 0; m_t = LOWC; m_ph = 3;
          end else if (!m_first && (m_gap >= GAPM || (in_valid && (int'(in_addr) / PAGEB) != m_page))) begin
            m_t = WCC; m_ph = 5;
          end else if (!m_first) m_gap++;
        end
        3: begin m_t--; if (m_t == 0) m_ph = 4; end
        4: begin m_gap = 0; if (m_rem == 0) begin m_t = WCC; m_ph = 5; end else m_ph = 2; end
        5: begin
          m_t--;
          if (m_t == 0) begin
            if (m_rem == 0) begin m_ph = 1; m_done = 1; end
            else begin m_first = 1; m_gap = 0; m_ph = 2; end
          end
        end
        default: ;
      endcase
    end
  end

  // host pair source
  int q_a[$], q_d[$], q_w[$];

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R2 oe_n", int'(ee_oe_n), 1);
      cmp("R3 we_n", int'(ee_we_n), (m_ph == 3) ? 0 : 1);
      cmp("R4 R8 ce_n", int'(ee_ce_n), (m_ph >= 2 && m_ph <= 4) ? 0 : 1);
      cmp("R5 R6 R7 in_ready", int'(in_ready), m_ready());
      cmp("R1 R9 busy", int'(busy), (m_ph == 1) ? 0 : 1);
      cmp("R9 done", int'(done), m_done);
      if (m_ph == 3 || m_ph == 4) begin
        cmp("R11 ee_addr", int'(ee_addr), m_addr);
        cmp("R11 ee_data", int'(ee_data), m_data);
      end
    end
    if (m_acc) begin
      void'(q_a.pop_front()); void'(q_d.pop_front()); void'(q_w.pop_front());
    end
    if (q_a.size() == 0) in_valid <= 0;
    else if (q_w[0] > 0) begin in_valid <= 0; q_w[0] = q_w[0] - 1; end
    else begin in_valid <= 1; in_addr <= AW'(q_a[0]); in_data <= DW'(q_d[0]); end
  end

  // memory observer
  int wmem[int];
  int writes = 0, pages = 0, dones = 0;
  always @(posedge ee_we_n) if (rst_n) begin wmem[int'(ee_addr)] = int'(ee_data); writes++; end
  always @(posedge ee_ce_n) if (rst_n) pages++;
  always @(posedge clk) if (rst_n && done) dones++;

  function automatic int pat(int a);
    return (a * 7 + 3) & 255;
  endfunction

  task automatic queue_burst(int base, int n, int stall_idx, int stall_len);
    for (int i = 0; i < n; i++) begin
      q_a.push_back(base + i); q_d.push_back(pat(base + i));
      q_w.push_back(i == stall_idx ? stall_len : 0);
    end
  endtask

  task automatic kick(int n);
    @(negedge clk); start <= 1; count <= CW'(n);
    @(negedge clk); start <= 0; count <= '0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1;
    while (busy) @(negedge clk);
    // R10: zero-length start ignored
    kick(0);
    repeat (3) @(negedge clk);
    cmp("R10 busy after zero count", int'(busy), 0);
    // back-to-back burst, one page
    queue_burst(16, 3, -1, 0); kick(3); wait_done();
    // R7: burst crosses page at 8
    queue_burst(6, 5, -1, 0); kick(5); wait_done();
    // R6: host stall past window; R10 start during wait ignored
    queue_burst(32, 3, 1, 40); kick(3);
    repeat (60) @(negedge clk);
    start <= 1; count <= 8'd7; @(negedge clk); start <= 0; count <= '0;
    wait_done();
    // R5: gap inside window keeps one page
    queue_burst(48, 2, 1, 20); kick(2); wait_done();
    repeat (5) @(negedge clk);
    for (int a = 16; a < 19; a++) cmp("R11 stored byte", wmem.exists(a) ? wmem[a] : -1, pat(a));
    for (int a = 6; a < 11; a++)  cmp("R7 R11 stored byte", wmem.exists(a) ? wmem[a] : -1, pat(a));
    for (int a = 32; a < 35; a++) cmp("R6 R11 stored byte", wmem.exists(a) ? wmem[a] : -1, pat(a));
    for (int a = 48; a < 50; a++) cmp("R5 R11 stored byte", wmem.exists(a) ? wmem[a] : -1, pat(a));
    cmp("R3 R11 write pulses", writes, 13);
    cmp("R6 R7 R8 page commits", pages, 6);
    cmp("R9 R10 done pulses", dones, 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule